// File: doc/BRIEF.md
# Sparse Associative Coherence Directory

This block keeps coherence state only for memory blocks that are cached somewhere in the system, instead of holding one entry for every memory block. Because only a small slice of memory (on the order of one percent) is cached at any moment, the entries are kept in a set-associative cache of directory records. Each record carries an address tag, a coherence state and a sharer bit vector with one bit per node. There are 16 nodes and 8 ways per set by default.

A coherence engine presents one lookup per cycle: a block address, the requesting node and whether the access is a read or a write. One cycle later the directory reports hit or miss together with the state and sharers that the record held before the access, and it updates the record. A miss takes a free way when the set has one. When the set is full, a record is evicted. The block announces the eviction with the victim's address and the nodes that must act: every sharer is invalidated, or the owner is asked to return a dirty line. The slot is refilled only after every one of those nodes has acknowledged. Requests to that set wait until then, as do requests that would need a second eviction.

Top module: `sparse_dir`

## Requirements
- R1: After reset every record is invalid, `req_ready` is high and neither `resp_valid` nor `evict_valid` is asserted.
- R2: An accepted request (`req_valid` and `req_ready` high at a rising edge) yields `resp_valid` for exactly the next cycle. It carries `resp_hit` and the record's prior state (00 invalid, 01 shared, 10 dirty) and sharer vector, or 00 and zero on a miss.
- R3: A read hit adds the requester's bit (bit index = `req_node`) to the sharers and leaves the record shared, including when it was dirty. A write hit makes the record dirty with only the requester's bit set.
- R4: A miss in a set with an invalid way fills the lowest-numbered invalid way at once. The new record is shared after a read or dirty after a write, with only the requester's bit set.
- R5: Each set has a 7-bit tree that starts at zero. Node n has children 2n+1 (bit value 0) and 2n+2 (bit value 1), and leaves 7 to 14 are ways 0 to 7. Every accepted request sets the bits on the path to the way it hit or filled so that they point away from that way. In a full set the victim is the way the tree points to if that way is shared, otherwise the lowest-numbered shared way, otherwise the tree's way.
- R6: A miss in a full set raises `evict_valid` for one cycle, in the cycle after acceptance. It carries the victim's block address, `evict_dirty` set if the victim was dirty, and `evict_nodes` equal to the victim's sharer vector (only the owner's bit for a dirty victim).
- R7: From the eviction until the last awaited acknowledgment, `req_ready` is low for requests to the evicting set and for requests that would evict elsewhere. A stalled request gets no response. The requester's new record is installed at the edge that takes the last acknowledgment.
- R8: An acknowledgment from a node that is not awaited, or one that arrives while no eviction is pending, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Block address; low SET_W bits select the set |
| req_node | input | log2(NODES) | Requesting node |
| req_ready | output | 1 | Request can be taken this cycle |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Record existed |
| resp_state | output | 2 | Prior state of the record |
| resp_sharers | output | NODES | Prior sharer vector |
| evict_valid | output | 1 | Eviction issued |
| evict_dirty | output | 1 | Victim was dirty: recall from owner |
| evict_addr | output | ADDR_W | Victim block address |
| evict_nodes | output | NODES | Nodes that must acknowledge |
| ack_valid | input | 1 | Acknowledgment or writeback completion |
| ack_node | input | log2(NODES) | Node acknowledging |

## Verification
`req_ready` is combinational, so the bench reads it one nanosecond after driving a request, before the rising edge. The response and any eviction are registered at the edge that accepts the request, and the bench samples them one nanosecond after that edge. An acknowledgment takes effect at its own edge, so the first request checked after the last acknowledgment must already see the installed record and the set free again. A reference model in the bench predicts each of these, including tree-based victim choice, and it advances only at the points where the design registers.

// File: rtl/sparse_dir.sv
module sparse_dir #(
  parameter int NODES  = 16,
  parameter int WAYS   = 8,
  parameter int SETS   = 16,
  parameter int ADDR_W = 20
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [$clog2(NODES)-1:0] req_node,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [1:0]               resp_state,
  output logic [NODES-1:0]         resp_sharers,
  output logic                     evict_valid,
  output logic                     evict_dirty,
  output logic [ADDR_W-1:0]        evict_addr,
  output logic [NODES-1:0]         evict_nodes,
  input  logic                     ack_valid,
  input  logic [$clog2(NODES)-1:0] ack_node
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PL_W  = WAYS - 1;
  localparam logic [1:0] ST_INV = 2'd0, ST_SH = 2'd1, ST_DIR = 2'd2;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [1:0]       st_q  [SETS][WAYS];
  logic [NODES-1:0] shv_q [SETS][WAYS];
  logic [PL_W-1:0]  plru_q [SETS];

  logic             busy_q;
  logic [SET_W-1:0] bset_q;
  logic [WAY_W-1:0] bway_q;
  logic [TAG_W-1:0] btag_q;
  logic [1:0]       bst_q;
  logic [NODES-1:0] bshv_q, pend_q;

  function automatic logic [WAY_W-1:0] plru_pick(input logic [PL_W-1:0] b);
    int n = 0;
    for (int l = 0; l < WAY_W; l++) n = 2*n + 1 + int'(1'(b >> n));
    return WAY_W'(n - PL_W);
  endfunction

  function automatic logic [PL_W-1:0] plru_touch(input logic [PL_W-1:0] b, input logic [WAY_W-1:0] w);
    int n = 0;
    logic d;
    for (int l = 0; l < WAY_W; l++) begin
      d = 1'(w >> (WAY_W-1-l));
      b = (b & ~(PL_W'(1) << n)) | (PL_W'(!d) << n);
      n = 2*n + 1 + int'(d);
    end
    return b;
  endfunction

  wire [SET_W-1:0] rset = req_addr[SET_W-1:0];
  wire [TAG_W-1:0] rtag = req_addr[ADDR_W-1:SET_W];

  logic hit, inv_any, sh_any;
  logic [WAY_W-1:0] hway, inv_way, sh_way, lru_way, vic_way, touch_way;

  always_comb begin
    hit = 1'b0; hway = '0; inv_any = 1'b0; inv_way = '0; sh_any = 1'b0; sh_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (st_q[rset][w] != ST_INV && tag_q[rset][w] == rtag) begin hit = 1'b1; hway = WAY_W'(w); end
      if (st_q[rset][w] == ST_INV) begin inv_any = 1'b1; inv_way = WAY_W'(w); end
      if (st_q[rset][w] == ST_SH)  begin sh_any  = 1'b1; sh_way  = WAY_W'(w); end
    end
  end

  assign lru_way = plru_pick(plru_q[rset]);

  always_comb begin
    if (inv_any)                        vic_way = inv_way;
    else if (st_q[rset][lru_way] == ST_SH) vic_way = lru_way;
    else if (sh_any)                    vic_way = sh_way;
    else                                vic_way = lru_way;
  end

  wire need_evict = !hit && !inv_any;
  wire set_busy   = busy_q && (rset == bset_q);
  assign req_ready = !set_busy && !(busy_q && need_evict);
  wire accept     = req_valid && req_ready;
  assign touch_way = hit ? hway : vic_way;

  wire [NODES-1:0] req_bit  = NODES'(1) << req_node;
  wire [1:0]       new_st   = req_write ? ST_DIR : ST_SH;
  wire [NODES-1:0] new_shv  = (hit && !req_write) ? (shv_q[rset][hway] | req_bit) : req_bit;
  wire [NODES-1:0] ack_bit  = ack_valid ? (NODES'(1) << ack_node) : '0;
  wire [NODES-1:0] pend_left = pend_q & ~ack_bit;
  wire finish = busy_q && (pend_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= ST_INV;
      end
      busy_q <= 1'b0; pend_q <= '0; bset_q <= '0; bway_q <= '0; btag_q <= '0;
      bst_q <= ST_INV; bshv_q <= '0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_state <= ST_INV; resp_sharers <= '0;
      evict_valid <= 1'b0; evict_dirty <= 1'b0; evict_addr <= '0; evict_nodes <= '0;
    end else begin
      resp_valid  <= accept;
      evict_valid <= 1'b0;
      if (accept) begin
        resp_hit     <= hit;
        resp_state   <= hit ? st_q[rset][hway] : ST_INV;
        resp_sharers <= hit ? shv_q[rset][hway] : '0;
        plru_q[rset] <= plru_touch(plru_q[rset], touch_way);
        if (need_evict) begin
          evict_valid <= 1'b1;
          evict_dirty <= (st_q[rset][vic_way] == ST_DIR);
          evict_addr  <= {tag_q[rset][vic_way], rset};
          evict_nodes <= shv_q[rset][vic_way];
          pend_q      <= shv_q[rset][vic_way];
          busy_q      <= 1'b1;
          bset_q <= rset; bway_q <= vic_way; btag_q <= rtag; bst_q <= new_st; bshv_q <= new_shv;
        end else begin
          st_q[rset][touch_way] <= new_st;
        end
      end
      if (finish) begin
        st_q[bset_q][bway_q] <= bst_q;
        busy_q <= 1'b0;
        pend_q <= '0;
      end else if (busy_q) begin
        pend_q <= pend_left;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !need_evict) begin
      tag_q[rset][touch_way] <= rtag;
      shv_q[rset][touch_way] <= new_shv;
    end
    if (finish) begin
      tag_q[bset_q][bway_q] <= btag_q;
      shv_q[bset_q][bway_q] <= bshv_q;
    end
  end

  // R6
  evict_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !evict_valid);
  // R6
  dirty_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && evict_dirty |-> $countones(evict_nodes) == 1);
  // R6
  shared_sharers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && !evict_dirty |-> evict_nodes != '0);
  // R2
  hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> resp_state != ST_INV && resp_sharers != '0);
  // R7
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> busy_q && pend_q == evict_nodes);
  // R7
  busy_set_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(busy_q) |-> $past(req_addr[SET_W-1:0]) != $past(bset_q));
endmodule

// File: tb/sim_sparse_dir.sv
`timescale 1ns/1ps
module sim_sparse_dir;
  localparam int NODES = 16, WAYS = 8, SETS = 16, ADDR_W = 20;
  localparam int SET_W = 4, TAG_W = ADDR_W - SET_W, LV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_node = '0, ack_node = '0;
  logic ack_valid = 1'b0;
  logic req_ready, resp_valid, resp_hit, evict_valid, evict_dirty;
  logic [1:0] resp_state;
  logic [NODES-1:0] resp_sharers, evict_nodes;
  logic [ADDR_W-1:0] evict_addr;

  always #2.5 clk = ~clk;

  sparse_dir #(.NODES(NODES), .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_node(req_node), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_state(resp_state),
    .resp_sharers(resp_sharers), .evict_valid(evict_valid), .evict_dirty(evict_dirty),
    .evict_addr(evict_addr), .evict_nodes(evict_nodes), .ack_valid(ack_valid), .ack_node(ack_node));

  logic [TAG_W-1:0] m_tag [SETS][WAYS];
  logic [1:0]       m_st  [SETS][WAYS];
  logic [NODES-1:0] m_shv [SETS][WAYS];
  logic [WAYS-2:0]  m_plru [SETS];
  bit m_busy;
  int m_bset, m_bway;
  logic [TAG_W-1:0] m_btag;
  logic [1:0] m_bst;
  logic [NODES-1:0] m_bshv, m_pend;
  int nchk = 0, nfail = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int lru_of(input logic [WAYS-2:0] b);
    int n = 0;
    for (int l = 0; l < LV; l++) n = 2*n + 1 + int'(b[n]);
    return n - (WAYS-1);
  endfunction

  function automatic logic [WAYS-2:0] lru_upd(input logic [WAYS-2:0] b, input int w);
    int n = 0;
    for (int l = LV-1; l >= 0; l--) begin
      int d = (w >> l) & 1;
      b[n] = (d == 0);
      n = 2*n + 1 + d;
    end
    return b;
  endfunction

  task automatic m_look(input logic [ADDR_W-1:0] a, output bit hit, output int hw,
                        output bit nev, output int vic);
    int s = int'(a[SET_W-1:0]);
    int inv = -1, sh = -1, p;
    hit = 0; hw = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_st[s][w] != 0 && m_tag[s][w] == a[ADDR_W-1:SET_W]) begin hit = 1; hw = w; end
      if (m_st[s][w] == 0 && inv < 0) inv = w;
      if (m_st[s][w] == 1 && sh < 0) sh = w;
    end
    p = lru_of(m_plru[s]);
    nev = !hit && inv < 0;
    if (inv >= 0) vic = inv;
    else if (m_st[s][p] == 1) vic = p;
    else if (sh >= 0) vic = sh;
    else vic = p;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int s);
    return {TAG_W'(tag), SET_W'(s)};
  endfunction

  task automatic do_req(input logic [ADDR_W-1:0] a, input int node, input bit wr, input string tg);
    bit hit, nev, rdy;
    int hw, vic, s, w;
    logic [NODES-1:0] bitv, nshv;
    logic [1:0] nst;
    s = int'(a[SET_W-1:0]);
    m_look(a, hit, hw, nev, vic);
    rdy = !(m_busy && (s == m_bset || nev));
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_node = 4'(node); req_write = wr;
    #1;
    chk({tg, " R7 ready"}, req_ready, rdy);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (!rdy) begin
      chk({tg, " R7 stalled request has no response"}, resp_valid, 0);
      return;
    end
    chk("R2 resp_valid", resp_valid, 1);
    chk("R2 resp_hit", resp_hit, hit);
    chk("R2 R4 resp_state", resp_state, hit ? m_st[s][hw] : 2'd0);
    chk("R3 R4 resp_sharers", resp_sharers, hit ? m_shv[s][hw] : '0);
    bitv = NODES'(1) << node;
    nst  = wr ? 2'd2 : 2'd1;
    nshv = (hit && !wr) ? (m_shv[s][hw] | bitv) : bitv;
    if (nev) begin
      chk("R6 evict_valid", evict_valid, 1);
      chk("R5 evict_addr", evict_addr, {m_tag[s][vic], SET_W'(s)});
      chk("R6 evict_dirty", evict_dirty, m_st[s][vic] == 2);
      chk("R6 evict_nodes", evict_nodes, m_shv[s][vic]);
      m_busy = 1; m_bset = s; m_bway = vic; m_btag = a[ADDR_W-1:SET_W];
      m_bst = nst; m_bshv = nshv; m_pend = m_shv[s][vic];
    end else begin
      chk("R6 no eviction", evict_valid, 0);
      w = hit ? hw : vic;
      m_tag[s][w] = a[ADDR_W-1:SET_W]; m_st[s][w] = nst; m_shv[s][w] = nshv;
    end
    m_plru[s] = lru_upd(m_plru[s], hit ? hw : vic);
  endtask

  task automatic do_ack(input int node);
    @(negedge clk);
    ack_valid = 1'b1; ack_node = 4'(node);
    @(posedge clk); #1;
    ack_valid = 1'b0;
    if (m_busy) begin
      m_pend[node] = 1'b0;
      if (m_pend == '0) begin
        m_tag[m_bset][m_bway] = m_btag; m_st[m_bset][m_bway] = m_bst;
        m_shv[m_bset][m_bway] = m_bshv; m_busy = 0;
      end
    end
  endtask

  function automatic int low_pend();
    for (int n = 0; n < NODES; n++) if (m_pend[n]) return n;
    return 0;
  endfunction

  task automatic ack_all();
    while (m_busy) do_ack(low_pend());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      m_plru[s] = '0;
      for (int w = 0; w < WAYS; w++) begin m_st[s][w] = 0; m_tag[s][w] = '0; m_shv[s][w] = '0; end
    end
    m_busy = 0; m_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 req_ready after reset", req_ready, 1);
    chk("R1 resp_valid after reset", resp_valid, 0);
    chk("R1 evict_valid after reset", evict_valid, 0);

    // R3: read/write hits, dirty record downgraded by a read
    do_req(mk(1, 5), 3, 0, "dir");
    do_req(mk(1, 5), 4, 0, "dir");
    do_req(mk(1, 5), 7, 1, "dir");
    do_req(mk(1, 5), 2, 0, "dir");
    do_req(mk(1, 5), 9, 0, "dir");

    // R5 R6 R7 R8: shared eviction, stall, stray ack
    for (int t = 0; t < 8; t++) do_req(mk(t, 7), t, 0, "fill");
    do_req(mk(8, 7), 9, 0, "evict");
    do_req(mk(0, 7), 1, 0, "busy set");
    do_req(mk(3, 12), 5, 0, "other set");
    for (int n = 0; n < NODES; n++)
      if (!m_pend[n]) begin do_ack(n); break; end
    do_req(mk(2, 7), 1, 0, "R8 stray ack");
    ack_all();
    do_req(mk(8, 7), 9, 0, "after install");

    // R6: all-dirty set recalls from owner
    for (int t = 0; t < 8; t++) do_req(mk(t, 9), t + 1, 1, "fill");
    do_req(mk(20, 9), 0, 0, "dirty evict");
    do_req(mk(21, 10), 0, 0, "fill");
    ack_all();

    // R5: shared way preferred over dirty ones
    for (int t = 0; t < 8; t++) do_req(mk(t, 10), t, t != 5, "fill");
    do_req(mk(30, 10), 11, 1, "prefer shared");
    ack_all();
    do_req(mk(31, 10), 12, 0, "prefer shared");
    ack_all();

    // R8: ack while idle has no effect
    do_ack(6);
    do_req(mk(30, 10), 11, 0, "R8 idle ack");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 8;
      if (m_busy && r < 3) begin
        if ($urandom % 4 == 0) do_ack($urandom % NODES);
        else do_ack(low_pend());
      end else if (!m_busy && r == 0) begin
        do_ack($urandom % NODES);
      end else begin
        do_req(mk($urandom % 12, $urandom % 4), $urandom % NODES, ($urandom % 4) == 0, "rand");
      end
    end
    ack_all();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule